// File: doc/BRIEF.md
# External memory bus strobe controller

This block drives the timing strobes of an 8-bit controller's multiplexed external memory bus. It sends an address-latch strobe, a read strobe and a write strobe, all active low except the latch strobe. It also decides whether a data-move access is served by on-chip extended RAM or goes out on the bus. The latch strobe free-runs at a fixed fraction of the clock, and the bus cycle drives it again whenever an access needs it.

A single control byte sets the block's behaviour. This byte can suppress the free-running latch strobe, select a short or a long read/write strobe, give the size of the on-chip RAM, force all data moves off-chip, and switch off the data-line pull-up. The instruction decoder raises a one-clock request (instruction fetch, code move, data read or data write) together with an address. The block then reports busy and pulses done once the access is complete.

Top module: `xmem_strobe_ctrl`

## Requirements
- R1: With suppression off, `ale_o` is high for one clock out of every 6 clocks, or one out of every 3 when `x2_mode_i` is high. A clock-phase counter cleared by reset sets the phase, and the first pulse comes in the 6th clock after reset.
- R2: When control bit 0 is 1 and no access is in progress, `ale_o` stays low and `ale_weak_pu_o` is high. Otherwise `ale_weak_pu_o` is low.
- R3: The read or write strobe stays low for 6 consecutive clocks when control bit 5 is 0, and for 30 when it is 1. The width is taken from the value of bit 5 in the cycle the request is accepted.
- R4: Control bits 3:2 give the on-chip RAM size: 0 means 256 bytes, 1 means 512, 2 means 768 and 3 means 1024. A data access with `wide_addr_i`=1 and control bit 1 at 0 is internal when `addr_i` is below that size, and external otherwise.
- R5: When control bit 1 is 1, every data access is external.
- R6: A data access with `wide_addr_i`=0 compares only `addr_i[7:0]` against the size. With control bit 1 at 0 it is therefore always internal, whatever the upper address bits are.
- R7: The control byte resets to 0. Bits 6 and 4 are never stored, and they read back as 0 on `cfg_rdata_o`.
- R8: `data_pu_en_o` is the inverse of control bit 7.
- R9: An external access follows the request's clock edge in this order: one clock of `ale_o`, then the strobe, then one clock of `done_o`. `busy_o` is high from the latch clock through the done clock. Requests that arrive while `busy_o` is high are dropped.
- R10: A data write drives `wr_no`. Fetches, code moves and data reads drive `rd_no`. When several requests arrive together, the priority is fetch, then code move, then data read, then data write.
- R11: An internal access asserts neither the bus strobes nor the access latch phase. The clock after acceptance has `done_o`, `busy_o` and `iram_sel_o` high together, and `iram_sel_o` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| x2_mode_i | input | 1 | double-speed mode, latch period 3 |
| cfg_we_i | input | 1 | control byte write enable |
| cfg_wdata_i | input | 8 | control byte write data |
| cfg_rdata_o | output | 8 | control byte readback |
| fetch_req_i | input | 1 | external instruction fetch request |
| code_req_i | input | 1 | code-move request |
| dread_req_i | input | 1 | data-move read request |
| dwrite_req_i | input | 1 | data-move write request |
| wide_addr_i | input | 1 | 1: 16-bit pointer access, 0: 8-bit indirect |
| addr_i | input | 16 | access address |
| ale_o | output | 1 | address latch strobe |
| ale_weak_pu_o | output | 1 | latch pin held weakly high |
| rd_no | output | 1 | read strobe, active low |
| wr_no | output | 1 | write strobe, active low |
| iram_sel_o | output | 1 | access served by on-chip RAM |
| busy_o | output | 1 | access in progress |
| done_o | output | 1 | access complete, one clock |
| data_pu_en_o | output | 1 | data-line weak pull-up enable |

## Verification
The bench counts latch pulses across whole periods in both speed modes and with suppression on. A wrong divider, or a leak of the free-running pulse while suppressed, shows up as a wrong count. It measures the low time of each strobe with the short and the long setting, and probes the addresses on either side of the largest size limit. An off-by-one comparison or a wrong size scale would send those addresses to the wrong memory. It also checks 8-bit accesses that carry stray upper address bits, a request raised during a busy access that must not cause a second done, and a fetch and a write raised together that must come out as a read.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LATCH, ST_STROBE, ST_DONE} xm_state_e;
  typedef enum logic [1:0] {AC_FETCH, AC_CODE, AC_RD, AC_WR} acc_kind_e;

  typedef struct packed {
    logic       pu_off;
    logic       rsv6;
    logic       stretch;
    logic       rsv4;
    logic [1:0] ram_size;
    logic       ext_ram;
    logic       ale_off;
  } xm_cfg_t;

  localparam logic [7:0] CFG_WMASK = 8'hAF;
endpackage

// File: rtl/xmem_ale_tick.sv
module xmem_ale_tick #(
  parameter int DIV_NORM = 6,
  parameter int DIV_X2   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x2_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV_NORM);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = x2_i ? CW'(DIV_X2 - 1) : CW'(DIV_NORM - 1);
  assign tick_o = (cnt_q == last);

  // a count left above the short period wraps at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/xmem_route.sv
module xmem_route
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE   = 256
) (
  input  acc_kind_e         kind_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              ext_ram_i,
  output logic              internal_o
);
  localparam int LW = ADDR_W + 1;

  logic [LW-1:0] limit;
  logic [LW-1:0] cmp_addr;
  logic          is_data;

  assign limit    = (LW'(size_i) + LW'(1)) * LW'(PAGE);
  assign cmp_addr = wide_i ? LW'(addr_i) : LW'(addr_i[7:0]);
  assign is_data  = (kind_i == AC_RD) || (kind_i == AC_WR);

  assign internal_o = is_data && !ext_ram_i && (cmp_addr < limit);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int STROBE_SHORT = 6,
  parameter int STROBE_LONG  = 30
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  acc_kind_e kind_i,
  input  logic      internal_i,
  input  logic      stretch_i,
  output logic      latch_o,
  output logic      rd_o,
  output logic      wr_o,
  output logic      done_o,
  output logic      busy_o,
  output logic      iram_o
);
  localparam int CNT_W = $clog2(STROBE_LONG + 1);

  xm_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic           is_wr_q, int_q, long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      int_q   <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          is_wr_q <= (kind_i == AC_WR);
          int_q   <= internal_i;
          long_q  <= stretch_i;
          state_q <= internal_i ? ST_DONE : ST_LATCH;
        end
        ST_LATCH: begin
          cnt_q   <= long_q ? CNT_W'(STROBE_LONG - 1) : CNT_W'(STROBE_SHORT - 1);
          state_q <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_DONE: begin
          int_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign latch_o = (state_q == ST_LATCH);
  assign rd_o    = (state_q == ST_STROBE) && !is_wr_q;
  assign wr_o    = (state_q == ST_STROBE) && is_wr_q;
  assign done_o  = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);
  assign iram_o  = (state_q == ST_DONE) && int_q;
endmodule

// File: rtl/xmem_strobe_ctrl.sv
module xmem_strobe_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE         = 256,
  parameter int DIV_NORM     = 6,
  parameter int DIV_X2       = 3,
  parameter int STROBE_SHORT = 6,
  parameter int STROBE_LONG  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x2_mode_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              fetch_req_i,
  input  logic              code_req_i,
  input  logic              dread_req_i,
  input  logic              dwrite_req_i,
  input  logic              wide_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ale_o,
  output logic              ale_weak_pu_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              iram_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              data_pu_en_o
);
  xm_cfg_t   cfg_q;
  acc_kind_e kind;
  logic      any_req, start, internal, tick, latch, rd, wr, busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= xm_cfg_t'(cfg_wdata_i & CFG_WMASK);
  end

  assign any_req = fetch_req_i | code_req_i | dread_req_i | dwrite_req_i;
  assign kind    = fetch_req_i ? AC_FETCH :
                   code_req_i  ? AC_CODE  :
                   dread_req_i ? AC_RD    : AC_WR;
  assign start   = any_req && !busy;

  xmem_ale_tick #(.DIV_NORM(DIV_NORM), .DIV_X2(DIV_X2)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x2_i   (x2_mode_i),
    .tick_o (tick)
  );

  xmem_route #(.ADDR_W(ADDR_W), .PAGE(PAGE)) i_route (
    .kind_i     (kind),
    .wide_i     (wide_addr_i),
    .addr_i     (addr_i),
    .size_i     (cfg_q.ram_size),
    .ext_ram_i  (cfg_q.ext_ram),
    .internal_o (internal)
  );

  xmem_seq #(.STROBE_SHORT(STROBE_SHORT), .STROBE_LONG(STROBE_LONG)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .kind_i     (kind),
    .internal_i (internal),
    .stretch_i  (cfg_q.stretch),
    .latch_o    (latch),
    .rd_o       (rd),
    .wr_o       (wr),
    .done_o     (done_o),
    .busy_o     (busy),
    .iram_o     (iram_sel_o)
  );

  assign ale_o         = latch | (tick & ~cfg_q.ale_off);
  assign ale_weak_pu_o = cfg_q.ale_off & ~busy;
  assign rd_no         = ~rd;
  assign wr_no         = ~wr;
  assign busy_o        = busy;
  assign cfg_rdata_o   = cfg_q;
  assign data_pu_en_o  = ~cfg_q.pu_off;
endmodule

// File: rtl/xmem_strobe_ctrl_chk.sv
module xmem_strobe_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] cfg_rdata_o,
  input logic       ale_o,
  input logic       rd_no,
  input logic       wr_no,
  input logic       iram_sel_o,
  input logic       busy_o,
  input logic       done_o
);
  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_latch_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) || $fell(wr_no)) |-> $past(ale_o));

  p_busy_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_int_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iram_sel_o |-> (rd_no && wr_no && done_o && busy_o));

  p_suppress_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[0] && !busy_o) |-> !ale_o);

  p_rsv_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[6] == 1'b0) && (cfg_rdata_o[4] == 1'b0));
endmodule

bind xmem_strobe_ctrl xmem_strobe_ctrl_chk i_chk (.*);

// File: tb/test_xmem_strobe_ctrl.sv
module test_xmem_strobe_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic x2 = 0, cfg_we = 0, fetch = 0, code = 0, dread = 0, dwrite = 0, wide = 0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;
  logic [15:0] addr = '0;
  logic ale, ale_pu, rd_n, wr_n, iram, busy, done, dpu;

  int total = 0, bad = 0;
  string tag = "R7";

  always #10 clk = ~clk;

  xmem_strobe_ctrl i_xmem_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .x2_mode_i(x2), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .fetch_req_i(fetch),
    .code_req_i(code), .dread_req_i(dread), .dwrite_req_i(dwrite),
    .wide_addr_i(wide), .addr_i(addr), .ale_o(ale), .ale_weak_pu_o(ale_pu),
    .rd_no(rd_n), .wr_no(wr_n), .iram_sel_o(iram), .busy_o(busy),
    .done_o(done), .data_pu_en_o(dpu));

  // behavioural reference model
  int m_cnt, m_st, m_w, m_wcnt;
  bit m_wr, m_int;
  logic [7:0] m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_w = 6; m_wcnt = 0; m_wr = 0; m_int = 0; m_cfg = 8'h00;
    end else begin
      int per;
      int lim;
      int cmpa;
      per = x2 ? 3 : 6;
      m_cnt = (m_cnt >= per - 1) ? 0 : m_cnt + 1;
      case (m_st)
        0: if (fetch || code || dread || dwrite) begin
          bit is_data;
          is_data = !fetch && !code;
          m_wr = is_data && !dread;
          lim  = (m_cfg[3:2] + 1) * 256;
          cmpa = wide ? int'(addr) : int'(addr[7:0]);
          m_int = is_data && !m_cfg[1] && (cmpa < lim);
          m_w  = m_cfg[5] ? 30 : 6;
          m_st = m_int ? 3 : 1;
        end
        1: begin m_wcnt = m_w; m_st = 2; end
        2: begin m_wcnt--; if (m_wcnt == 0) m_st = 3; end
        default: begin m_st = 0; m_int = 0; end
      endcase
      if (cfg_we) m_cfg = cfg_wdata & 8'hAF;
    end
  end

  task automatic cmp(string sig, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      int per;
      per = x2 ? 3 : 6;
      cmp("ale", ale, (m_st == 1) || (!m_cfg[0] && m_cnt == per - 1));
      cmp("ale_pu", ale_pu, m_cfg[0] && m_st == 0);
      cmp("rd_n", rd_n, !(m_st == 2 && !m_wr));
      cmp("wr_n", wr_n, !(m_st == 2 && m_wr));
      cmp("done", done, m_st == 3);
      cmp("busy", busy, m_st != 0);
      cmp("iram", iram, m_st == 3 && m_int);
      cmp("cfg", cfg_rdata, m_cfg);
      cmp("dpu", dpu, !m_cfg[7]);
    end
  end

  task automatic wr_cfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic count_ale(int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); #6; if (ale) c++; end
  endtask

  // kind: 0 fetch 1 code 2 read 3 write
  task automatic access(int kind, bit w, logic [15:0] a,
                        output int rdl, output int wrl, output int irm, output int dn);
    rdl = 0; wrl = 0; irm = 0; dn = 0;
    @(negedge clk);
    fetch = (kind == 0); code = (kind == 1); dread = (kind == 2); dwrite = (kind == 3);
    wide = w; addr = a;
    @(negedge clk);
    fetch = 0; code = 0; dread = 0; dwrite = 0;
    for (int i = 0; i < 80; i++) begin
      #6;
      if (!rd_n) rdl++;
      if (!wr_n) wrl++;
      if (iram) irm++;
      if (done) dn++;
      if (done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, rl, wl, im, dn;
    repeat (3) @(negedge clk);
    #6;
    tag = "R7";
    cmp("reset cfg", cfg_rdata, 0);
    cmp("reset rd_n", rd_n, 1);
    cmp("reset busy", busy, 0);
    tag = "R8"; cmp("reset dpu", dpu, 1);
    rst_n = 1;

    tag = "R1";
    count_ale(60, c); cmp("ale count normal", c, 10);
    x2 = 1; @(negedge clk); count_ale(60, c); cmp("ale count x2", c, 20);
    x2 = 0; @(negedge clk);

    tag = "R2";
    wr_cfg(8'h01);
    count_ale(60, c); cmp("ale suppressed", c, 0);
    cmp("weak pu", ale_pu, 1);

    tag = "R3";
    wr_cfg(8'h00);
    access(2, 1, 16'h0300, rl, wl, im, dn);
    cmp("short rd width", rl, 6); cmp("ext iram", im, 0);
    wr_cfg(8'h20);
    access(2, 1, 16'h0300, rl, wl, im, dn);
    cmp("long rd width", rl, 30);

    tag = "R4";
    wr_cfg(8'h0C);
    access(2, 1, 16'h03FF, rl, wl, im, dn);
    cmp("top of 1k internal", im, 1); cmp("no rd internal", rl, 0);
    access(2, 1, 16'h0400, rl, wl, im, dn);
    cmp("past 1k external", im, 0); cmp("rd past 1k", rl, 6);
    wr_cfg(8'h04);
    access(3, 1, 16'h01FF, rl, wl, im, dn); cmp("512 edge internal", im, 1);
    access(3, 1, 16'h0200, rl, wl, im, dn); cmp("512 edge external", wl, 6);

    tag = "R5";
    wr_cfg(8'h0E);
    access(2, 1, 16'h0010, rl, wl, im, dn);
    cmp("extram forces bus", im, 0); cmp("extram rd", rl, 6);

    tag = "R6";
    wr_cfg(8'h00);
    access(2, 0, 16'hFF10, rl, wl, im, dn);
    cmp("narrow internal", im, 1);

    tag = "R10";
    access(3, 1, 16'h8000, rl, wl, im, dn);
    cmp("write uses wr", wl, 6); cmp("write no rd", rl, 0);
    @(negedge clk); fetch = 1; dwrite = 1; wide = 1; addr = 16'h0005;
    @(negedge clk); fetch = 0; dwrite = 0;
    rl = 0; wl = 0;
    repeat (10) begin #6; if (!rd_n) rl++; if (!wr_n) wl++; @(negedge clk); end
    cmp("fetch wins rd", rl, 6); cmp("fetch wins no wr", wl, 0);

    tag = "R9";
    @(negedge clk); code = 1; addr = 16'h1234;
    @(negedge clk); code = 0;
    repeat (3) @(negedge clk);
    dread = 1; @(negedge clk); dread = 0;
    dn = 0;
    repeat (20) begin #6; if (done) dn++; @(negedge clk); end
    cmp("busy drops req", dn, 1);

    tag = "R11";
    wr_cfg(8'h01);
    access(3, 0, 16'h0042, rl, wl, im, dn);
    cmp("internal iram", im, 1); cmp("internal no wr", wl, 0);
    cmp("internal done", dn, 1);

    tag = "R7";
    wr_cfg(8'hFF);
    #6; cmp("rsv masked", cfg_rdata, 8'hAF);
    tag = "R8"; cmp("pu off", dpu, 0);
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule